// File: doc/BRIEF.md
# Two-Region Power-of-Two Address Remapper

This block sits on the request side of a single bus port, between a processor and the fabric, and rewrites each outgoing address. Two configurable windows are supported. Each window is a naturally aligned power-of-two span. The span is described by a single match word whose run of trailing one bits gives its size. When an address falls in an enabled window, the high-order bits of the address are swapped for those of a programmed target, and the offset within the span is kept. Addresses outside every enabled window leave the block untouched. A typical use is to let software run at one fixed link address while the hardware steers its fetches or loads to whichever physical image is active.

The translation path is purely combinational. A small register write port programs each window's enable, match word and target word. Each window also has a one-way guard bit. Once software clears that bit, the window's settings are frozen until the next reset.

Top module: `napot_remap`

## Requirements
- R1: Region 0 has priority over region 1. When an address lies in both enabled windows, `addr_o` is formed from region 0, while `hit_o` still reports both raw matches (bit r for region r).
- R2: An address that lies in no enabled window appears unchanged on `addr_o`. A region whose enable is 0 never asserts its `hit_o` bit.
- R3: A match word with exactly k trailing one bits defines a window of 2^(k+1) bytes. The window is aligned to its own size, and its base is the match word with those k+1 low bits cleared. For example, 0x8000_7FFF covers 0x8000_0000 through 0x8000_FFFF.
- R4: On a hit, the address bits above the window size come from the target word, and the bits within the window come from `addr_i`.
- R5: Reset (`rst_n` low, asynchronous) leaves every enable, match word and target word at 0, and every guard bit at 1. After reset, every address passes through with `hit_o` = 0.
- R6: Writing `wr_field_i`=0 with `wr_data_i[0]`=0 clears that region's guard bit. Writing 1 there has no effect, so a cleared guard stays cleared until reset.
- R7: While a region's guard bit is 0, writes to its enable (`wr_field_i`=1, value in `wr_data_i[0]`), match word (`wr_field_i`=2) or target word (`wr_field_i`=3) are ignored. Writes to the other region still apply.
- R8: Translation adds no cycle of latency. A register write sampled at a rising edge changes the translation from that edge on. In the cycle the write is presented, the translation still uses the old settings.
- R9: An all-ones match word makes the window cover the whole address space. Every address then hits that region, and the result equals `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_region_i | input | $clog2(NUM_REGIONS) | Region targeted by the write |
| wr_field_i | input | 2 | 0 guard, 1 enable, 2 match word, 3 target word |
| wr_data_i | input | ADDR_W | Write value |
| addr_i | input | ADDR_W | Incoming request address |
| addr_o | output | ADDR_W | Translated address |
| hit_o | output | NUM_REGIONS | Raw per-region match, bit r for region r |

## Verification
A configuration write and a translation can land in the same cycle. The bench provokes this by presenting a write to the very region that covers the address on the lines. It first compares `addr_o` just after the falling edge, and expects the old mapping there. It then compares again after the capturing rising edge, and expects the new mapping. The bench covers three kinds of write in this way: a target change, a window resize, and a guard clear followed by a rejected write. Expected results come from an interval model: each window is computed as a base plus a power-of-two size, using 64-bit arithmetic.

// File: rtl/napot_remap_pkg.sv
package napot_remap_pkg;

  // Register selector carried on the write port.
  typedef enum logic [1:0] {
    FLD_GUARD  = 2'd0,
    FLD_ENABLE = 2'd1,
    FLD_MATCH  = 2'd2,
    FLD_TARGET = 2'd3
  } cfg_field_e;

endpackage

// File: rtl/napot_region_regs.sv
module napot_region_regs
  import napot_remap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_i,
  input  cfg_field_e        field_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic              guard_o,
  output logic              en_o,
  output logic [ADDR_W-1:0] match_o,
  output logic [ADDR_W-1:0] target_o
);

  logic              guard_q;
  logic              en_q;
  logic [ADDR_W-1:0] match_q;
  logic [ADDR_W-1:0] target_q;

  // Settings may change only while the guard is still set.
  logic cfg_wr;
  assign cfg_wr = sel_wr_i && guard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q  <= 1'b1;
      en_q     <= 1'b0;
      match_q  <= '0;
      target_q <= '0;
    end else begin
      // The guard only ever falls; a written 1 is discarded.
      if (sel_wr_i && field_i == FLD_GUARD && !data_i[0]) guard_q <= 1'b0;
      if (cfg_wr && field_i == FLD_ENABLE) en_q     <= data_i[0];
      if (cfg_wr && field_i == FLD_MATCH)  match_q  <= data_i;
      if (cfg_wr && field_i == FLD_TARGET) target_q <= data_i;
    end
  end

  assign guard_o  = guard_q;
  assign en_o     = en_q;
  assign match_o  = match_q;
  assign target_o = target_q;

endmodule

// File: rtl/napot_region_match.sv
module napot_region_match #(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] match_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] span_o,
  output logic [ADDR_W-1:0] xlat_o
);

  // Offset-bit mask: trailing ones plus the first zero above them.
  // The increment wraps to zero on an all-ones word, so the mask
  // becomes all ones and the window spans the full space.
  function automatic logic [ADDR_W-1:0] span_mask(input logic [ADDR_W-1:0] v);
    return v ^ (v + ADDR_W'(1));
  endfunction

  function automatic logic [ADDR_W-1:0] splice(input logic [ADDR_W-1:0] hi_src,
                                               input logic [ADDR_W-1:0] lo_src,
                                               input logic [ADDR_W-1:0] m);
    return (hi_src & ~m) | (lo_src & m);
  endfunction

  logic [ADDR_W-1:0] span;
  assign span   = span_mask(match_i);
  assign hit_o  = en_i && ((addr_i & ~span) == (match_i & ~span));
  assign span_o = span;
  assign xlat_o = splice(target_i, addr_i, span);

endmodule

// File: rtl/napot_prio_sel.sv
module napot_prio_sel #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 2
) (
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [NUM_REGIONS-1:0]              hit_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  xlat_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  span_i,
  output logic [NUM_REGIONS-1:0]              win_o,
  output logic [ADDR_W-1:0]                   win_span_o,
  output logic [ADDR_W-1:0]                   addr_o
);

  // Lowest index that hits wins; with no hit the address passes.
  always_comb begin
    logic found;
    found      = 1'b0;
    win_o      = '0;
    win_span_o = '0;
    addr_o     = addr_i;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hit_i[r] && !found) begin
        found      = 1'b1;
        win_o[r]   = 1'b1;
        win_span_o = span_i[r];
        addr_o     = xlat_i[r];
      end
    end
  end

endmodule

// File: rtl/napot_remap.sv
module napot_remap
  import napot_remap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 2,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [RIDX_W-1:0]      wr_region_i,
  input  logic [1:0]             wr_field_i,
  input  logic [ADDR_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [NUM_REGIONS-1:0] hit_o
);

  cfg_field_e field;
  assign field = cfg_field_e'(wr_field_i);

  // Named internal wires, visible to the bound checker.
  logic [NUM_REGIONS-1:0]             guard_vec;
  logic [NUM_REGIONS-1:0]             en_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] match_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] target_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] span_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat_vec;
  logic [NUM_REGIONS-1:0]             win_vec;
  logic [ADDR_W-1:0]                  win_span;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic sel_wr;
    assign sel_wr = wr_en_i && (wr_region_i == RIDX_W'(r));

    napot_region_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr_i (sel_wr),
      .field_i  (field),
      .data_i   (wr_data_i),
      .guard_o  (guard_vec[r]),
      .en_o     (en_vec[r]),
      .match_o  (match_vec[r]),
      .target_o (target_vec[r])
    );

    napot_region_match #(.ADDR_W(ADDR_W)) u_match (
      .en_i     (en_vec[r]),
      .match_i  (match_vec[r]),
      .target_i (target_vec[r]),
      .addr_i   (addr_i),
      .hit_o    (hit_o[r]),
      .span_o   (span_vec[r]),
      .xlat_o   (xlat_vec[r])
    );
  end

  napot_prio_sel #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_sel (
    .addr_i     (addr_i),
    .hit_i      (hit_o),
    .xlat_i     (xlat_vec),
    .span_i     (span_vec),
    .win_o      (win_vec),
    .win_span_o (win_span),
    .addr_o     (addr_o)
  );

endmodule

// File: rtl/napot_remap_checker.sv
module napot_remap_checker #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [ADDR_W-1:0]                addr_i,
  input logic [ADDR_W-1:0]                addr_o,
  input logic [NUM_REGIONS-1:0]           hit_o,
  input logic [NUM_REGIONS-1:0]           win_vec,
  input logic [ADDR_W-1:0]                win_span,
  input logic [NUM_REGIONS-1:0]           guard_vec,
  input logic [NUM_REGIONS-1:0]           en_vec,
  input logic [NUM_REGIONS-1:0][ADDR_W-1:0] match_vec,
  input logic [NUM_REGIONS-1:0][ADDR_W-1:0] target_vec
);

  assert_single_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  assert_region0_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o[0] |-> win_vec[0]);

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o == '0) |-> (addr_o == addr_i));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o != '0) |-> (((addr_o ^ addr_i) & win_span) == '0));

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_chk
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[r] |-> !hit_o[r]);

    assert_guard_one_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(guard_vec[r]));

    assert_frozen_when_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !guard_vec[r] |=> ($stable(en_vec[r]) && $stable(match_vec[r])
                         && $stable(target_vec[r])));

    assert_full_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec[r] && (&match_vec[r])) |-> hit_o[r]);
  end

endmodule

bind napot_remap napot_remap_checker #(
  .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .hit_o      (hit_o),
  .win_vec    (win_vec),
  .win_span   (win_span),
  .guard_vec  (guard_vec),
  .en_vec     (en_vec),
  .match_vec  (match_vec),
  .target_vec (target_vec)
);

// File: tb/napot_remap_bench.sv
`timescale 1ns/1ps
module napot_remap_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_region_i = '0;
  logic [1:0]  wr_field_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] addr_o;
  logic [1:0]  hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  napot_remap u_napot_remap (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_region_i(wr_region_i),
    .wr_field_i(wr_field_i), .wr_data_i(wr_data_i), .addr_i(addr_i),
    .addr_o(addr_o), .hit_o(hit_o)
  );

  // Reference state, kept from the requirements.
  logic        m_guard [2];
  logic        m_en    [2];
  logic [31:0] m_match [2];
  logic [31:0] m_tgt   [2];

  function automatic int trailing_ones(input logic [31:0] v);
    int n = 0;
    bit run = 1;
    for (int i = 0; i < 32; i++) begin
      if (run && v[i]) n++;
      else run = 0;
    end
    return n;
  endfunction

  // Interval model: window = [base, base + size).
  task automatic model(input logic [31:0] a, output logic [31:0] exp_a,
                       output logic [1:0] exp_h);
    bit taken = 0;
    exp_a = a;
    exp_h = '0;
    for (int r = 0; r < 2; r++) begin
      longint unsigned size, base, tbase;
      size  = 64'd1 << (trailing_ones(m_match[r]) + 1);
      base  = (64'(m_match[r]) / size) * size;
      tbase = (64'(m_tgt[r]) / size) * size;
      if (m_en[r] && 64'(a) >= base && 64'(a) < base + size) begin
        exp_h[r] = 1'b1;
        if (!taken) begin
          taken = 1;
          exp_a = 32'(tbase + (64'(a) - base));
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] a);
    logic [31:0] ea;
    logic [1:0]  eh;
    model(a, ea, eh);
    checks++;
    if (addr_o !== ea || hit_o !== eh) begin
      fails++;
      $display("FAIL %s addr=%h: got out=%h hit=%b, expected out=%h hit=%b",
               tag, a, addr_o, hit_o, ea, eh);
    end
  endtask

  task automatic model_write(input int r, input int f, input logic [31:0] d);
    if (f == 0) begin
      if (!d[0]) m_guard[r] = 1'b0;
    end else if (m_guard[r]) begin
      if (f == 1) m_en[r] = d[0];
      if (f == 2) m_match[r] = d;
      if (f == 3) m_tgt[r] = d;
    end
  endtask

  task automatic write(input int r, input int f, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_region_i = 1'(r); wr_field_i = 2'(f); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    model_write(r, f, d);
  endtask

  task automatic probe(input string tag, input logic [31:0] a);
    @(negedge clk);
    addr_i = a;
    #0.5;
    check(tag, a);
  endtask

  // Write and translation in the same cycle (R8): old map first, new after the edge.
  task automatic write_probe(input string tag, input int r, input int f,
                             input logic [31:0] d, input logic [31:0] a);
    @(negedge clk);
    wr_en_i = 1'b1; wr_region_i = 1'(r); wr_field_i = 2'(f); wr_data_i = d;
    addr_i = a;
    #0.5;
    check({tag, " R8 pre-edge"}, a);
    @(posedge clk);
    #0.5;
    model_write(r, f, d);
    check({tag, " R8 post-edge"}, a);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, got hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 2; r++) begin
      m_guard[r] = 1'b1; m_en[r] = 1'b0; m_match[r] = '0; m_tgt[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: reset state passes everything through.
    probe("R5 reset", 32'h0000_0000);
    probe("R5 reset", 32'h0000_0001);
    probe("R5 reset", 32'hFFFF_FFFF);
    probe("R5 reset", 32'h8000_4321);

    // R3/R4/R2: sweep window size over every k, region 0 only.
    write(0, 3, 32'h3C5A_F00F);
    write(0, 1, 32'h1);
    for (int k = 0; k < 31; k++) begin
      longint unsigned size, base;
      size = 64'd1 << (k + 1);
      base = (64'hA5C3_96E1 / size) * size;
      write(0, 2, 32'(base | ((64'd1 << k) - 1)));
      probe("R3 base", 32'(base));
      probe("R3 top", 32'(base + size - 1));
      probe("R2 below", 32'(base - 1));
      probe("R2 above", 32'(base + size));
      probe("R4 mid", 32'(base + size / 2 + 64'd1));
    end
    // Example from R3.
    write(0, 2, 32'h8000_7FFF);
    probe("R3 example lo", 32'h8000_0000);
    probe("R3 example hi", 32'h8000_FFFF);
    probe("R3 example out", 32'h8001_0000);

    // R2: disabled region ignored.
    write(0, 1, 32'h0);
    probe("R2 disabled", 32'h8000_1234);

    // R1: overlapping windows.
    write(0, 2, 32'h1000_7FFF);  write(0, 3, 32'h2000_0000); write(0, 1, 32'h1);
    write(1, 2, 32'h1007_FFFF);  write(1, 3, 32'h4000_0000); write(1, 1, 32'h1);
    probe("R1 both", 32'h1000_0ABC);
    probe("R1 both edge", 32'h1000_FFFF);
    probe("R1 only r1", 32'h1001_0000);
    probe("R1 only r1 top", 32'h100F_FFFF);
    probe("R2 neither", 32'h1010_0000);

    // R8: write and translate in the same cycle.
    write_probe("target swap", 0, 3, 32'h5550_0000, 32'h1000_0123);
    write_probe("resize", 0, 2, 32'h1000_0FFF, 32'h1000_3000);

    // R9: all-ones match in region 1, region 0 off.
    write(0, 1, 32'h0);
    write(1, 2, 32'hFFFF_FFFF);
    probe("R9 full low", 32'h0000_0000);
    probe("R9 full high", 32'hFFFF_FFFF);
    probe("R9 full mid", 32'h7654_3210);

    // R6/R7: guard clear on region 0, then rejected writes.
    write(0, 2, 32'h0000_00FF); write(0, 3, 32'hABCD_0000); write(0, 1, 32'h1);
    write_probe("R6 guard clear", 0, 0, 32'h0, 32'h0000_0042);
    write(0, 0, 32'h1);                 // R6: 1 is discarded
    write(0, 3, 32'h1111_0000);         // R7: ignored
    probe("R7 target frozen", 32'h0000_0042);
    write(0, 2, 32'h0000_FFFF);         // R7: ignored
    probe("R7 match frozen", 32'h0000_1042);
    write(0, 1, 32'h0);                 // R7: ignored
    probe("R7 enable frozen", 32'h0000_0010);
    write_probe("R7 rejected", 0, 1, 32'h0, 32'h0000_0011);
    // Region 1 still writable (R7).
    write(1, 2, 32'h0000_FFFF); write(1, 3, 32'h9000_0000);
    probe("R7 other region", 32'h0000_1042);
    probe("R7 other region pri", 32'h0000_0042);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule